// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog counter for a low-power domain. A free-running raw count advances on each cycle in which a slow clock-enable pulse is present. A 4-bit shift setting picks which 16-bit slice of that count forms the scaled count. The scaled count is compared against one programmable threshold. When the scaled count reaches or passes the threshold, a pending flag is raised and drives the interrupt line. If the configuration allows it, a sticky reset request is also raised, and it stays up until the block itself is reset.

Software reaches the block through a plain single-cycle register port. Writes take effect on the clock edge. Reads are combinational from the word address. The register port is control traffic and has no stream semantics, so it has no valid/ready handshake and never applies back-pressure. Every write except one to the key register is dropped unless the key word was written immediately before it. A feed word written to the feed register restarts the count. Counting can be set to run all the time, to run only while the processor reports that it is awake, or to stop.

Register word addresses: 0 configuration, 1 raw count, 2 scaled count (read-only), 3 feed (reads 0), 4 key (bit 0 reads 1 while unlocked), 5 threshold. Configuration bits: [3:0] shift, 8 reset enable, 9 zero-on-match, 12 run always, 13 run while awake, 28 pending.

Top module: `wdt_guard`

## Requirements
- R1: After reset, the block is in this state: configuration reads 0, count reads 0, threshold reads 0x0000FFFF, the key register reads 0, and irq and reset_req are low.
- R2: With configuration bit 12 set, the count rises by exactly one on each clock edge where tick_en is high. It does not change on edges where tick_en is low.
- R3: With bit 13 set and bit 12 clear, the count advances only on edges where core_asleep is low. With both bits clear, the count does not advance.
- R4: The scaled count (address 2) equals the raw count shifted right by configuration bits [3:0], keeping the low 16 bits. The threshold is compared against this value.
- R5: On the edge after the scaled count is greater than or equal to the threshold, irq and configuration bit 28 go high. A configuration write with bit 28 at 0 clears them only if no match holds at that edge.
- R6: reset_req is set together with pending only while configuration bit 8 is set. Once set, it stays high until rst_n is asserted.
- R7: With configuration bit 9 set, the count is 0 on the edge after a match, instead of incrementing.
- R8: A write to any address other than 4 is ignored unless the previous write was 0x0051F15E to address 4. While the block is unlocked, address 4 reads 1.
- R9: An unlocked state lasts for one further write only. A write of any other value to address 4 locks the block.
- R10: Writing 0x0D09F00D to address 3 while unlocked clears the count. Any other value written there leaves the count unchanged, but it still uses up the unlock.
- R11: An unlocked write to address 1 loads the count, and it takes priority over an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow clock-enable; one count step per high cycle |
| core_asleep | input | 1 | High while the processor sleeps |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Pending interrupt |
| reset_req | output | 1 | Sticky reset request |

## Verification
The bound checker watches rules that hold on every cycle:
- a threshold write while the block is locked leaves the threshold unchanged;
- the unlock never outlives one write;
- a match always raises the interrupt on the next edge;
- the reset request is sticky, and it rises only while reset is enabled;
- the count holds when there is no tick and no write;
- zero-on-match clears the count.

Some behaviours can only be shown by the bench scenarios. These are the exact count after a run of ticks, the awake-only gating, the shifted view at several shift settings, the feed magic compared with other values, the priority of a load over an increment, and the clearing of pending while a match persists compared with after it ends.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int SCALE_W = 4;

  typedef enum logic [2:0] {
    A_CFG    = 3'd0,
    A_COUNT  = 3'd1,
    A_SCALED = 3'd2,
    A_FEED   = 3'd3,
    A_KEY    = 3'd4,
    A_CMP    = 3'd5
  } wdt_addr_e;

  localparam int B_RST_EN = 8;
  localparam int B_ZERO   = 9;
  localparam int B_ALWAYS = 12;
  localparam int B_AWAKE  = 13;
  localparam int B_PEND   = 28;

  typedef struct packed {
    logic [SCALE_W-1:0] scale;
    logic               rst_en;
    logic               zero_on_match;
    logic               run_always;
    logic               run_awake;
  } wdt_cfg_t;

endpackage

// File: rtl/wdt_keylock.sv
module wdt_keylock #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] KEY_MAGIC = 32'h0051_F15E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              key_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked,
  output logic              accept
);

  // Any write re-arms or drops the lock: only the key word to the key
  // register leaves it open, and it stays open for one write.
  always_ff @(posedge clk) begin
    if (!rst_n)
      unlocked <= 1'b0;
    else if (wr_en)
      unlocked <= key_sel && (wdata == DATA_W'(KEY_MAGIC));
  end

  assign accept = wr_en && !key_sel && unlocked;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               run,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  input  logic               clear,
  input  logic               zero_hit,
  input  logic [SCALE_W-1:0] scale,
  output logic [CNT_W-1:0]   count,
  output logic [CMP_W-1:0]   scaled
);

  localparam int NSLICE = 1 << SCALE_W;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (load)
      count <= load_val;
    else if (clear || zero_hit)
      count <= '0;
    else if (tick_en && run)
      count <= count + 1'b1;
  end

  // One candidate window per shift amount; windows past the top of the
  // count are zero-filled.
  logic [CMP_W-1:0] slice [NSLICE];

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    if (s + CMP_W <= CNT_W) begin : g_full
      assign slice[s] = count[s+CMP_W-1:s];
    end else if (s < CNT_W) begin : g_part
      assign slice[s] = CMP_W'(count[CNT_W-1:s]);
    end else begin : g_none
      assign slice[s] = '0;
    end
  end

  assign scaled = slice[scale];

endmodule

// File: rtl/wdt_compare.sv
module wdt_compare #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMP_W-1:0] scaled,
  input  logic [CMP_W-1:0] threshold,
  input  logic             rst_en,
  input  logic             pend_wr,
  input  logic             pend_wdata,
  output logic             match,
  output logic             pending,
  output logic             reset_req
);

  assign match = (scaled >= threshold);

  // A live match wins over a software clear on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      pending   <= match || (pend_wr ? pend_wdata : pending);
      reset_req <= reset_req || (match && rst_en);
    end
  end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int          CNT_W      = 31,
  parameter int          CMP_W      = 16,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] KEY_MAGIC  = 32'h0051_F15E,
  parameter logic [31:0] FEED_MAGIC = 32'h0D09_F00D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              core_asleep,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              reset_req
);

  wdt_addr_e        addr_e;
  wdt_cfg_t         cfg_q;
  logic [CMP_W-1:0] cmp_q;
  logic [CNT_W-1:0] count_q;
  logic [CMP_W-1:0] scaled;
  logic             unlocked;
  logic             accept;
  logic             match;
  logic             pending;
  logic             run;
  logic             wr_cfg, wr_cmp, wr_cnt, wr_feed;

  assign addr_e = wdt_addr_e'(reg_addr);

  wdt_keylock #(.DATA_W(DATA_W), .KEY_MAGIC(KEY_MAGIC)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .key_sel  (addr_e == A_KEY),
    .wdata    (reg_wdata),
    .unlocked (unlocked),
    .accept   (accept)
  );

  assign wr_cfg  = accept && (addr_e == A_CFG);
  assign wr_cmp  = accept && (addr_e == A_CMP);
  assign wr_cnt  = accept && (addr_e == A_COUNT);
  assign wr_feed = accept && (addr_e == A_FEED) && (reg_wdata == DATA_W'(FEED_MAGIC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmp_q <= '1;
    end else begin
      if (wr_cfg) begin
        cfg_q.scale         <= reg_wdata[SCALE_W-1:0];
        cfg_q.rst_en        <= reg_wdata[B_RST_EN];
        cfg_q.zero_on_match <= reg_wdata[B_ZERO];
        cfg_q.run_always    <= reg_wdata[B_ALWAYS];
        cfg_q.run_awake     <= reg_wdata[B_AWAKE];
      end
      if (wr_cmp)
        cmp_q <= reg_wdata[CMP_W-1:0];
    end
  end

  assign run = cfg_q.run_always || (cfg_q.run_awake && !core_asleep);

  wdt_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .run      (run),
    .load     (wr_cnt),
    .load_val (reg_wdata[CNT_W-1:0]),
    .clear    (wr_feed),
    .zero_hit (cfg_q.zero_on_match && match),
    .scale    (cfg_q.scale),
    .count    (count_q),
    .scaled   (scaled)
  );

  wdt_compare #(.CMP_W(CMP_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .scaled     (scaled),
    .threshold  (cmp_q),
    .rst_en     (cfg_q.rst_en),
    .pend_wr    (wr_cfg),
    .pend_wdata (reg_wdata[B_PEND]),
    .match      (match),
    .pending    (pending),
    .reset_req  (reset_req)
  );

  assign irq = pending;

  always_comb begin
    reg_rdata = '0;
    unique case (addr_e)
      A_CFG: begin
        reg_rdata[SCALE_W-1:0] = cfg_q.scale;
        reg_rdata[B_RST_EN]    = cfg_q.rst_en;
        reg_rdata[B_ZERO]      = cfg_q.zero_on_match;
        reg_rdata[B_ALWAYS]    = cfg_q.run_always;
        reg_rdata[B_AWAKE]     = cfg_q.run_awake;
        reg_rdata[B_PEND]      = pending;
      end
      A_COUNT:  reg_rdata = DATA_W'(count_q);
      A_SCALED: reg_rdata = DATA_W'(scaled);
      A_KEY:    reg_rdata[0] = unlocked;
      A_CMP:    reg_rdata = DATA_W'(cmp_q);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CNT_W = 31,
  parameter int CMP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [2:0]       reg_addr,
  input logic             tick_en,
  input logic             irq,
  input logic             reset_req,
  input logic             unlocked,
  input logic             match,
  input logic             zero_on_match,
  input logic             rst_en,
  input logic [CMP_W-1:0] cmp_q,
  input logic [CNT_W-1:0] count
);

  assert_locked_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 3'd5 && !unlocked) |=> $stable(cmp_q));

  assert_unlock_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr != 3'd4) |=> !unlocked);

  assert_match_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> irq);

  assert_rstreq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);

  assert_rstreq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(rst_en));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && !tick_en && !(zero_on_match && match)) |=> $stable(count));

  assert_zero_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_on_match && match && !reg_wr_en) |=> (count == '0));

endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr_en     (reg_wr_en),
  .reg_addr      (reg_addr),
  .tick_en       (tick_en),
  .irq           (irq),
  .reset_req     (reset_req),
  .unlocked      (unlocked),
  .match         (match),
  .zero_on_match (cfg_q.zero_on_match),
  .rst_en        (cfg_q.rst_en),
  .cmp_q         (cmp_q),
  .count         (count_q)
);

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] KEY  = 32'h0051_F15E;
  localparam logic [31:0] FEED = 32'h0D09_F00D;
  localparam int          SEL_IRQ = 8;
  localparam int          SEL_RST = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        core_asleep = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        reset_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard u_wdt_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .core_asleep (core_asleep),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .reset_req   (reset_req)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr_en = 1'b1;
    step(1);
    reg_wr_en = 1'b0;
  endtask

  task automatic uwr(input logic [2:0] a, input logic [31:0] d);
    wr(3'd4, KEY);
    wr(a, d);
  endtask

  task automatic tick(input int n);
    tick_en = 1'b1;
    step(n);
    tick_en = 1'b0;
  endtask

  // Driver side of the scoreboard: point the read port, queue the expectation.
  task automatic expect_sel(input int sel, input logic [31:0] exp, input string tag);
    if (sel < 8) reg_addr = 3'(sel);
    sb.push_back('{sel, exp, tag});
    step(1);
  endtask

  // Monitor side: sample away from the active edge and compare.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t       it;
      logic [31:0] act;
      it = sb.pop_front();
      if (it.sel == SEL_IRQ)      act = {31'd0, irq};
      else if (it.sel == SEL_RST) act = {31'd0, reset_req};
      else                        act = reg_rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    expect_sel(0, 32'h0, "R1 cfg after reset");
    expect_sel(1, 32'h0, "R1 count after reset");
    expect_sel(5, 32'h0000_FFFF, "R1 threshold after reset");
    expect_sel(4, 32'h0, "R1 locked after reset");
    expect_sel(SEL_IRQ, 32'h0, "R1 irq after reset");
    expect_sel(SEL_RST, 32'h0, "R1 reset_req after reset");

    wr(3'd0, 32'h0000_1000);
    expect_sel(0, 32'h0, "R8 locked cfg write ignored");
    wr(3'd4, KEY);
    expect_sel(4, 32'h1, "R8 key unlocks");
    wr(3'd0, 32'h0000_1000);
    expect_sel(0, 32'h0000_1000, "R9 unlocked cfg write taken");
    expect_sel(4, 32'h0, "R9 unlock consumed");

    tick(5);
    expect_sel(1, 32'd5, "R2 five ticks");
    step(3);
    expect_sel(1, 32'd5, "R2 no tick no count");

    uwr(3'd0, 32'h0000_1002);
    expect_sel(2, 32'd1, "R4 scaled shift 2 of 5");
    uwr(3'd1, 32'h0000_0123);
    expect_sel(1, 32'h123, "R11 count load");
    expect_sel(2, 32'h48, "R4 scaled shift 2 of 0x123");

    wr(3'd4, KEY);
    tick_en = 1'b1;
    wr(3'd1, 32'h40);
    tick_en = 1'b0;
    expect_sel(1, 32'h40, "R11 load beats increment");

    uwr(3'd3, 32'h0000_1234);
    expect_sel(1, 32'h40, "R10 wrong feed keeps count");
    expect_sel(4, 32'h0, "R9 wrong feed used unlock");
    uwr(3'd3, FEED);
    expect_sel(1, 32'h0, "R10 feed clears count");

    uwr(3'd0, 32'h0000_2000);
    core_asleep = 1'b1;
    tick(4);
    expect_sel(1, 32'd0, "R3 asleep no count");
    core_asleep = 1'b0;
    tick(3);
    expect_sel(1, 32'd3, "R3 awake counts");
    uwr(3'd0, 32'h0);
    tick(3);
    expect_sel(1, 32'd3, "R3 no mode stopped");
    uwr(3'd0, 32'h0000_2000);

    uwr(3'd5, 32'd4);
    expect_sel(SEL_IRQ, 32'h0, "R5 below threshold");
    tick(1);
    step(1);
    expect_sel(SEL_IRQ, 32'h1, "R5 match sets irq");
    expect_sel(0, 32'h1000_2000, "R5 pending bit in cfg");
    expect_sel(SEL_RST, 32'h0, "R6 no reset without enable");
    uwr(3'd0, 32'h0000_2000);
    expect_sel(SEL_IRQ, 32'h1, "R5 clear loses to live match");
    uwr(3'd3, FEED);
    uwr(3'd0, 32'h0000_2000);
    expect_sel(SEL_IRQ, 32'h0, "R5 clear after match ends");

    uwr(3'd0, 32'h0000_1300);
    tick(6);
    expect_sel(1, 32'd1, "R7 zero on match then count");
    expect_sel(SEL_IRQ, 32'h1, "R7 pending from match");
    expect_sel(SEL_RST, 32'h1, "R6 reset request raised");
    uwr(3'd0, 32'h0000_1000);
    expect_sel(SEL_IRQ, 32'h0, "R5 pending cleared");
    expect_sel(SEL_RST, 32'h1, "R6 reset request sticky");

    uwr(3'd0, 32'h0000_0003);
    uwr(3'd5, 32'd2);
    uwr(3'd1, 32'd15);
    step(1);
    expect_sel(SEL_IRQ, 32'h0, "R4 scaled 1 below 2");
    uwr(3'd1, 32'd16);
    step(1);
    expect_sel(2, 32'd2, "R4 scaled shift 3 of 16");
    expect_sel(SEL_IRQ, 32'h1, "R4 scaled compare matches");

    wr(3'd1, 32'h55);
    expect_sel(1, 32'd16, "R8 locked count write ignored");

    step(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1-flow actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule